// File: doc/BRIEF.md
# Reset Sequencer with Source Detection

This block is the reset controller of a small microcontroller. Its inputs are an active-low power-on request, the raw level of a shared open-drain reset pin, and single-cycle request strobes from a watchdog and a clock monitor. Its output is the core reset. After power-up it holds the core in reset for a fixed stabilisation count. During normal running, any reset condition starts a fixed sequence. The block pulls the pin low for a short pulse and releases it. A few cycles later it checks whether something outside is still holding the pin low. If so, the event is an external reset. If not, the latched internal cause is reported.

The controller is a single state machine with these states:
- `ST_STAB`: the stabilisation count.
- `ST_PINWAIT`: the count has finished but the pin is still low.
- `ST_RUN`: the core is running.
- `ST_DRIVE`: the block is pulling the pin low.
- `ST_GAP`: the pin has been released and the block waits out the synchroniser and sample delay.
- `ST_WAITHI`: classification is done and the block waits for the pin to read high.

Transitions:
- Power-on request, from any state: to `ST_STAB`, asynchronously.
- `ST_STAB` → `ST_RUN` or `ST_PINWAIT`: at the end of the count. The pin level picks the target.
- `ST_PINWAIT` → `ST_RUN`: the pin reads high.
- `ST_RUN` → `ST_DRIVE`: a request wins arbitration, and its cause is latched.
- `ST_DRIVE` → `ST_GAP`: the drive count ends.
- `ST_GAP` → `ST_WAITHI`: classification.
- `ST_WAITHI` → `ST_RUN`: the pin reads high.

The raw pin goes through a two-flop synchroniser before any decision uses it.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `por_n` rises, with the pin high, `core_rst` stays 1 through the first 4063 rising clock edges and is 0 after the 4064th.
- R2: If the pin is low when the stabilisation count ends, `core_rst` stays 1 until the pin goes high. It then drops within 4 cycles.
- R3: A reset sequence pulls the pin low (`pin_drive_low` = 1) for exactly 4 consecutive cycles, then releases it.
- R4: Cycles after the release are numbered from 0, the first cycle with the pin released. The raw pin level in cycle 2 decides the class. Low means external. High means the latched internal cause.
- R5: Requests in the same cycle resolve with the clock monitor first, then the watchdog, then a low pin.
- R6: The flags are `flag_por`, `flag_ext`, `flag_wdog` and `flag_cmon`. At most one is 1 at any time. None is set while a sequence runs. Exactly one is set whenever the core is out of reset, and it names the cause of the last reset.
- R7: `core_rst` stays 1 for the whole drive and sample sequence. It drops only after classification and after the synchronised pin has read high.
- R8: A low `por_n` at any time, including during a sequence, immediately releases the pin, asserts `core_rst` and sets only `flag_por`. Its release restarts the full 4064-cycle count.
- R9: Watchdog and clock-monitor strobes that arrive while a sequence runs are ignored, and the reported cause is unchanged.
- R10: A low pin during running starts the same sequence and ends with `flag_ext` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por_n | input | 1 | Power-on request, active low, asynchronous |
| pin_in | input | 1 | Raw level of the open-drain reset pin |
| pin_drive_low | output | 1 | 1 pulls the reset pin low |
| wdog_req | input | 1 | Watchdog timeout strobe |
| cmon_req | input | 1 | Clock-monitor failure strobe |
| core_rst | output | 1 | Core reset, active high |
| flag_por | output | 1 | Last reset was power-on |
| flag_ext | output | 1 | Last reset was external |
| flag_wdog | output | 1 | Last reset was the watchdog |
| flag_cmon | output | 1 | Last reset was the clock monitor |

## Verification
A wrong state or counter shows up at the ports within the sequence it affects:
- An off-by-one drive or gap count changes the pulse width on `pin_drive_low`. It also moves the sample point, so a pin released exactly in cycle 2 or cycle 3 after release lands in the wrong flag.
- A wrong latched cause or a broken priority appears as the wrong flag at the first cycle `core_rst` falls.
- A stale state after a power-on abort shows up as early release of `core_rst` or a missing `flag_por`.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_STAB    = 3'd0,
        ST_PINWAIT = 3'd1,
        ST_RUN     = 3'd2,
        ST_DRIVE   = 3'd3,
        ST_GAP     = 3'd4,
        ST_WAITHI  = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_EXT  = 2'd0,
        CAUSE_WDOG = 2'd1,
        CAUSE_CMON = 2'd2
    } cause_t;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_arb.sv
module rst_seq_arb
    import rst_seq_pkg::*;
(
    input  logic   cmon_i,
    input  logic   wdog_i,
    input  logic   pin_low_i,
    output logic   hit_o,
    output cause_t cause_o
);
    always_comb begin
        hit_o   = cmon_i | wdog_i | pin_low_i;
        if (cmon_i) begin
            cause_o = CAUSE_CMON;
        end else if (wdog_i) begin
            cause_o = CAUSE_WDOG;
        end else begin
            cause_o = CAUSE_EXT;
        end
    end
endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags
    import rst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   clr_i,
    input  logic   set_i,
    input  cause_t cause_i,
    output logic   por_o,
    output logic   ext_o,
    output logic   wdog_o,
    output logic   cmon_o
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            por_o  <= 1'b1;
            ext_o  <= 1'b0;
            wdog_o <= 1'b0;
            cmon_o <= 1'b0;
        end else if (clr_i) begin
            por_o  <= 1'b0;
            ext_o  <= 1'b0;
            wdog_o <= 1'b0;
            cmon_o <= 1'b0;
        end else if (set_i) begin
            ext_o  <= (cause_i == CAUSE_EXT);
            wdog_o <= (cause_i == CAUSE_WDOG);
            cmon_o <= (cause_i == CAUSE_CMON);
        end
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int STAB_CYCLES  = 4064,
    parameter int DRIVE_CYCLES = 4,
    parameter int SAMPLE_GAP   = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_in,
    output logic pin_drive_low,
    input  logic wdog_req,
    input  logic cmon_req,
    output logic core_rst,
    output logic flag_por,
    output logic flag_ext,
    output logic flag_wdog,
    output logic flag_cmon
);
    // Gap covers synchroniser latency so the decision sees raw cycle SAMPLE_GAP.
    localparam int GAP_CYCLES = SAMPLE_GAP + SYNC_STAGES + 1;
    localparam int MAX_A      = (STAB_CYCLES > DRIVE_CYCLES) ? STAB_CYCLES : DRIVE_CYCLES;
    localparam int CNT_MAX    = (MAX_A > GAP_CYCLES) ? MAX_A : GAP_CYCLES;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] STAB_LAST  = CNT_W'(STAB_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    seq_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    cause_t           cause_q, arb_cause, flag_cause;
    logic             pin_hi, arb_hit, cause_ld, classify, leave_run;

    rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (pin_in),
        .q_o   (pin_hi)
    );

    rst_seq_arb u_arb (
        .cmon_i    (cmon_req),
        .wdog_i    (wdog_req),
        .pin_low_i (~pin_hi),
        .hit_o     (arb_hit),
        .cause_o   (arb_cause)
    );

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state   <= ST_STAB;
            cnt     <= '0;
            cause_q <= CAUSE_EXT;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (cause_ld) begin
                cause_q <= arb_cause;
            end
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        cause_ld  = 1'b0;
        classify  = 1'b0;
        leave_run = 1'b0;
        unique case (state)
            ST_STAB: begin
                if (cnt == STAB_LAST) begin
                    cnt_nxt   = '0;
                    state_nxt = pin_hi ? ST_RUN : ST_PINWAIT;
                end else begin
                    cnt_nxt = cnt + CNT_ONE;
                end
            end
            ST_PINWAIT: begin
                if (pin_hi) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (arb_hit) begin
                    state_nxt = ST_DRIVE;
                    cnt_nxt   = '0;
                    cause_ld  = 1'b1;
                    leave_run = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (cnt == DRIVE_LAST) begin
                    state_nxt = ST_GAP;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CNT_ONE;
                end
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) begin
                    state_nxt = ST_WAITHI;
                    cnt_nxt   = '0;
                    classify  = 1'b1;
                end else begin
                    cnt_nxt = cnt + CNT_ONE;
                end
            end
            ST_WAITHI: begin
                if (pin_hi) begin
                    state_nxt = ST_RUN;
                end
            end
            default: begin
                state_nxt = ST_STAB;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pin_drive_low = (state == ST_DRIVE);
        core_rst      = (state != ST_RUN);
        flag_cause    = pin_hi ? cause_q : CAUSE_EXT;
    end

    rst_seq_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .clr_i   (leave_run),
        .set_i   (classify),
        .cause_i (flag_cause),
        .por_o   (flag_por),
        .ext_o   (flag_ext),
        .wdog_o  (flag_wdog),
        .cmon_o  (flag_cmon)
    );
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
    parameter int STAB_CYCLES  = 4064,
    parameter int DRIVE_CYCLES = 4
) (
    input logic       clk,
    input logic       por_n,
    input logic       drive,
    input logic       core_rst,
    input logic       pin_hi,
    input logic [3:0] flags
);
    localparam int SW = $clog2(STAB_CYCLES + 1);
    localparam int DW = $clog2(DRIVE_CYCLES + 2);
    localparam logic [SW-1:0] STAB_V  = SW'(STAB_CYCLES);
    localparam logic [DW-1:0] DRIVE_V = DW'(DRIVE_CYCLES);

    logic [SW-1:0] since_rst;
    logic [DW-1:0] run_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            since_rst <= '0;
            run_len   <= '0;
        end else begin
            if (since_rst != STAB_V) since_rst <= since_rst + SW'(1);
            if (!drive)                 run_len <= '0;
            else if (run_len != DRIVE_V + DW'(1)) run_len <= run_len + DW'(1);
        end
    end

    a_r1_por_hold: assert property (@(posedge clk) disable iff (!por_n)
        (since_rst < STAB_V) |-> core_rst);

    a_r3_drive_max: assert property (@(posedge clk) disable iff (!por_n)
        drive |-> (run_len < DRIVE_V));

    a_r3_drive_exact: assert property (@(posedge clk) disable iff (!por_n)
        $fell(drive) |-> (run_len == DRIVE_V));

    a_r7_drive_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        drive |-> core_rst);

    a_r7_release_pin_high: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst) |-> $past(pin_hi));

    a_r6_onehot: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(flags));

    a_r6_one_when_running: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst |-> ($countones(flags) == 1));

    a_r6_clear_in_seq: assert property (@(posedge clk) disable iff (!por_n)
        drive |-> (flags == 4'b0000));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
    .STAB_CYCLES  (STAB_CYCLES),
    .DRIVE_CYCLES (DRIVE_CYCLES)
) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .drive    (pin_drive_low),
    .core_rst (core_rst),
    .pin_hi   (pin_hi),
    .flags    ({flag_por, flag_ext, flag_wdog, flag_cmon})
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int STAB       = 4064;
    localparam logic [3:0] F_POR = 4'b1000, F_EXT = 4'b0100,
                           F_WDG = 4'b0010, F_CMN = 4'b0001;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_hold = 1'b0;
    logic wdog_req = 1'b0, cmon_req = 1'b0;
    logic pin_drive_low, core_rst;
    logic flag_por, flag_ext, flag_wdog, flag_cmon;
    logic pin_in;
    logic [3:0] flags;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic prev_rst = 1'b1;

    assign pin_in = ~(pin_drive_low | ext_hold);
    assign flags  = {flag_por, flag_ext, flag_wdog, flag_cmon};

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_ctrl i_rst_seq_ctrl (
        .clk           (clk),
        .por_n         (por_n),
        .pin_in        (pin_in),
        .pin_drive_low (pin_drive_low),
        .wdog_req      (wdog_req),
        .cmon_req      (cmon_req),
        .core_rst      (core_rst),
        .flag_por      (flag_por),
        .flag_ext      (flag_ext),
        .flag_wdog     (flag_wdog),
        .flag_cmon     (flag_cmon)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_flags(input logic [3:0] f, input string req);
        exp_q.push_back(f);
        tag_q.push_back(req);
    endtask

    // Monitor: compare flags on every release of core reset
    always @(negedge clk) begin
        if (por_n && prev_rst && !core_rst) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected release", int'(flags), 0);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(flags == e, t, int'(flags), int'(e));
            end
        end
        prev_rst = core_rst;
    end

    task automatic wait_run(input string req);
        for (int i = 0; i < 40 && core_rst; i++) @(negedge clk);
        check(!core_rst, req, int'(core_rst), 0);
    endtask

    task automatic por_release_count;
        por_n = 1'b1;
        repeat (STAB - 1) @(negedge clk);
        check(core_rst == 1'b1, "R1 held before count end", int'(core_rst), 1);
        @(negedge clk);
        check(core_rst == 1'b0, "R1 released at count end", int'(core_rst), 0);
    endtask

    task automatic strobe(input bit w, input bit c);
        @(negedge clk);
        wdog_req = w;
        cmon_req = c;
        @(negedge clk);
        wdog_req = 1'b0;
        cmon_req = 1'b0;
    endtask

    task automatic count_drive(input string req);
        int n = 0;
        while (pin_drive_low && n < 20) begin
            n++;
            check(core_rst == 1'b1, "R7 reset during drive", int'(core_rst), 1);
            @(negedge clk);
        end
        check(n == 4, req, n, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check(core_rst == 1'b1, "R8 reset asserts core", int'(core_rst), 1);
        check(pin_drive_low == 1'b0, "R8 no drive in reset", int'(pin_drive_low), 0);
        check(flags == F_POR, "R6 power-on flag", int'(flags), int'(F_POR));

        // R1: stabilisation count
        expect_flags(F_POR, "R1 flags after power-on");
        por_release_count();
        repeat (3) @(negedge clk);

        // R3 and R4: watchdog, pin free
        expect_flags(F_WDG, "R4 watchdog internal");
        strobe(1'b1, 1'b0);
        count_drive("R3 drive length");
        wait_run("R7 release after watchdog");
        repeat (3) @(negedge clk);

        // Clock monitor alone
        expect_flags(F_CMN, "R4 clock monitor internal");
        strobe(1'b0, 1'b1);
        count_drive("R3 drive length cmon");
        wait_run("R7 release after cmon");
        repeat (3) @(negedge clk);

        // R5: both strobes together
        expect_flags(F_CMN, "R5 cmon beats wdog");
        strobe(1'b1, 1'b1);
        wait_run("R5 release");
        repeat (3) @(negedge clk);

        // R5: watchdog beats a low pin seen in the same cycle
        expect_flags(F_WDG, "R5 wdog beats pin");
        @(negedge clk);
        ext_hold = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wdog_req = 1'b1;
        @(negedge clk);
        wdog_req = 1'b0;
        ext_hold = 1'b0;
        wait_run("R5 release pin");
        repeat (3) @(negedge clk);

        // R10: external pulse
        expect_flags(F_EXT, "R10 external pin reset");
        @(negedge clk);
        ext_hold = 1'b1;
        repeat (8) @(negedge clk);
        ext_hold = 1'b0;
        wait_run("R10 release");
        repeat (3) @(negedge clk);

        // R4 boundary: pin high in release cycle 2 -> internal
        expect_flags(F_WDG, "R4 high at cycle 2");
        strobe(1'b1, 1'b0);
        ext_hold = 1'b1;
        count_drive("R3 drive length boundary");
        repeat (2) @(negedge clk);
        ext_hold = 1'b0;
        wait_run("R4 release boundary a");
        repeat (3) @(negedge clk);

        // R4 boundary: pin high only from cycle 3 -> external
        expect_flags(F_EXT, "R4 low at cycle 2");
        strobe(1'b1, 1'b0);
        ext_hold = 1'b1;
        count_drive("R3 drive length boundary b");
        repeat (3) @(negedge clk);
        ext_hold = 1'b0;
        wait_run("R4 release boundary b");
        repeat (3) @(negedge clk);

        // R9: strobes during a sequence are ignored
        expect_flags(F_WDG, "R9 late strobes ignored");
        strobe(1'b1, 1'b0);
        cmon_req = 1'b1;
        @(negedge clk);
        cmon_req = 1'b0;
        repeat (3) @(negedge clk);
        strobe(1'b1, 1'b1);
        wait_run("R9 release");
        check(flags == F_WDG, "R9 cause unchanged", int'(flags), int'(F_WDG));
        repeat (3) @(negedge clk);

        // R2: pin held low past the count
        @(negedge clk);
        por_n = 1'b0;
        ext_hold = 1'b1;
        expect_flags(F_POR, "R2 flags after pin wait");
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (STAB + 20) @(negedge clk);
        check(core_rst == 1'b1, "R2 held while pin low", int'(core_rst), 1);
        ext_hold = 1'b0;
        for (int i = 0; i < 4 && core_rst; i++) @(negedge clk);
        check(core_rst == 1'b0, "R2 release after pin high", int'(core_rst), 0);
        repeat (3) @(negedge clk);

        // R8: power-on aborts a running sequence
        strobe(1'b1, 1'b0);
        check(pin_drive_low == 1'b1, "R8 sequence started", int'(pin_drive_low), 1);
        por_n = 1'b0;
        #1;
        check(pin_drive_low == 1'b0, "R8 drive released", int'(pin_drive_low), 0);
        check(flags == F_POR, "R8 only power-on flag", int'(flags), int'(F_POR));
        expect_flags(F_POR, "R8 flags after restart");
        repeat (2) @(negedge clk);
        check(core_rst == 1'b1, "R8 core held", int'(core_rst), 1);
        por_release_count();
        repeat (3) @(negedge clk);

        check(exp_q.size() == 0, "R6 all releases seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule